// File: doc/BRIEF.md
# Configurable-Aspect Dual-Port RAM

This block is a 1,152-bit memory with one write-only port and one read-only port, each on its own clock. A two-bit shape select gives the same storage one of four logical shapes: 64 words of 18 bits, 128 of 9, 256 of 4 or 512 of 2. Both ports present a 9-bit address and an 18-bit data bus. In each shape only the low address bits that the depth needs are used, and only the low data bits that the width needs are carried.

The read port runs in one of two static modes. In the clocked mode a read enable samples the addressed word into an output register on the read clock edge. In the combinational mode the read data follows the read address and the array contents with no clock. Logical word `i` of width `w` occupies bits `[i*w +: w]` of one flat bit vector, so data stays consistent while the shape is held. Contents seen after a shape change are not defined.

Top module: `cfg_aspect_ram`

## Requirements
- R1: The `shape` input selects the logical organisation: 2'b00 gives 64x18, 2'b01 gives 128x9, 2'b10 gives 256x4 and 2'b11 gives 512x2. A word written in a shape reads back unchanged in that shape.
- R2: Only the low 6, 7, 8 or 9 address bits (for shapes 00, 01, 10, 11) are used on either port; higher address bits are ignored, so addresses that differ only there name the same word.
- R3: Only the low 18, 9, 4 or 2 bits of `wrData` are stored; bits of `rdData` above the current width read as zero.
- R4: A write happens only on a rising edge of `wrClk` with `wrEn` high; with `wrEn` low the array is unchanged.
- R5: With `asyncRd` low, a rising edge of `rdClk` with `rdEn` high loads the addressed word into the output register, and `rdData` shows it after that edge.
- R6: With `asyncRd` low and `rdEn` low, `rdData` holds its previous value on every `rdClk` edge, whatever `rdAddr` does.
- R7: With `asyncRd` high, `rdData` follows `rdAddr` and the array contents without any clock, including a word written at the immediately preceding `wrClk` edge.
- R8: A clocked read of an address issued after a write to that address has completed returns the newly written data.
- R9: While `rstN` is low the read output register is zero.
- R10: Words inside one shape do not overlap: writing one address leaves every other word of that shape unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rstN | input | 1 | Active-low asynchronous clear of the read output register |
| shape | input | 2 | Logical organisation select |
| asyncRd | input | 1 | 1 = combinational read, 0 = clocked read |
| wrClk | input | 1 | Write port clock |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 9 | Write word address |
| wrData | input | 18 | Write data, low bits used |
| rdClk | input | 1 | Read port clock |
| rdEn | input | 1 | Read enable for the clocked read |
| rdAddr | input | 9 | Read word address |
| rdData | output | 18 | Read data, unused high bits zero |

## Verification
The bench fills every word of each shape and reads it all back through both read modes, so a wrong offset multiplier or an overlapping word map shows up as corrupted neighbours. It writes with random junk in the unused address and data bits, which a design that failed to mask would turn into aliasing onto the wrong word or into stray high bits on the read bus. It parks the read address elsewhere with the enable low to catch a register that reloads regardless, issues writes with the enable low to catch stores that ignore it, and reads back immediately after a write in both read modes to catch a stale-data path.

// File: rtl/cfg_ram_pkg.sv
package cfg_ram_pkg;
  parameter int ADDR_W     = 9;
  parameter int DATA_W     = 18;
  parameter int TOTAL_BITS = 1152;
  parameter int SHAPE_W    = 2;
  localparam int OFF_W     = $clog2(TOTAL_BITS);
  localparam int WIDTH_W   = $clog2(DATA_W + 1);
  localparam int MIN_ABITS = ADDR_W - (1 << SHAPE_W) + 1;

  typedef struct packed {
    logic               wrStb;
    logic               rdStb;
    logic               asyncSel;
    logic [WIDTH_W-1:0] width;
    logic [OFF_W-1:0]   wrOff;
    logic [OFF_W-1:0]   rdOff;
  } ramStrobes_t;

  function automatic logic [WIDTH_W-1:0] shapeWidth(input logic [SHAPE_W-1:0] s);
    return WIDTH_W'(DATA_W >> s);
  endfunction

  function automatic logic [ADDR_W-1:0] shapeAddrMask(input logic [SHAPE_W-1:0] s);
    logic [ADDR_W-1:0] m;
    for (int b = 0; b < ADDR_W; b++) m[b] = (b < MIN_ABITS + int'(s));
    return m;
  endfunction
endpackage

// File: rtl/cfg_ram_ctrl.sv
module cfg_ram_ctrl
  import cfg_ram_pkg::*;
(
  input  logic [SHAPE_W-1:0] shape,
  input  logic               asyncRd,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  rdAddr,
  output ramStrobes_t        ctl
);
  logic [ADDR_W-1:0]  addrMask;
  logic [WIDTH_W-1:0] widthCur;
  logic [ADDR_W-1:0]  wrWord;
  logic [ADDR_W-1:0]  rdWord;

  always_comb begin
    addrMask = shapeAddrMask(shape);
    widthCur = shapeWidth(shape);
    wrWord   = wrAddr & addrMask;
    rdWord   = rdAddr & addrMask;
  end

  always_comb begin
    ctl.wrStb    = wrEn;
    ctl.rdStb    = rdEn & ~asyncRd;
    ctl.asyncSel = asyncRd;
    ctl.width    = widthCur;
    ctl.wrOff    = OFF_W'(wrWord) * OFF_W'(widthCur);
    ctl.rdOff    = OFF_W'(rdWord) * OFF_W'(widthCur);
  end
endmodule

// File: rtl/cfg_ram_datapath.sv
module cfg_ram_datapath
  import cfg_ram_pkg::*;
(
  input  logic              rstN,
  input  logic              wrClk,
  input  logic              rdClk,
  input  ramStrobes_t       ctl,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [TOTAL_BITS-1:0] store;
  logic [DATA_W-1:0]     wordOut;
  logic [DATA_W-1:0]     rdReg;

  always_ff @(posedge wrClk) begin
    if (ctl.wrStb) begin
      for (int k = 0; k < DATA_W; k++) begin
        if (k < int'(ctl.width)) store[int'(ctl.wrOff) + k] <= wrData[k];
      end
    end
  end

  always_comb begin
    wordOut = '0;
    for (int k = 0; k < DATA_W; k++) begin
      if (k < int'(ctl.width)) wordOut[k] = store[int'(ctl.rdOff) + k];
    end
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)          rdReg <= '0;
    else if (ctl.rdStb) rdReg <= wordOut;
  end

  assign rdData = ctl.asyncSel ? wordOut : rdReg;

  // R5
  rd_capture_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    ctl.rdStb |=> rdReg == $past(wordOut));

  // R6
  rd_hold_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    !ctl.rdStb |=> $stable(rdReg));

  // R3
  unused_bits_zero_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    ctl.asyncSel |-> (rdData >> ctl.width) == '0);

  // R10
  rd_range_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    (int'(ctl.rdOff) + int'(ctl.width)) <= TOTAL_BITS);

  // R10
  wr_range_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    ctl.wrStb |-> (int'(ctl.wrOff) + int'(ctl.width)) <= TOTAL_BITS);
endmodule

// File: rtl/cfg_aspect_ram.sv
module cfg_aspect_ram
  import cfg_ram_pkg::*;
(
  input  logic              rstN,
  input  logic [1:0]        shape,
  input  logic              asyncRd,
  input  logic              wrClk,
  input  logic              wrEn,
  input  logic [8:0]        wrAddr,
  input  logic [17:0]       wrData,
  input  logic              rdClk,
  input  logic              rdEn,
  input  logic [8:0]        rdAddr,
  output logic [17:0]       rdData
);
  ramStrobes_t ctl;

  cfg_ram_ctrl uCtrl (
    .shape   (shape),
    .asyncRd (asyncRd),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .rdEn    (rdEn),
    .rdAddr  (rdAddr),
    .ctl     (ctl)
  );

  cfg_ram_datapath uData (
    .rstN   (rstN),
    .wrClk  (wrClk),
    .rdClk  (rdClk),
    .ctl    (ctl),
    .wrData (wrData),
    .rdData (rdData)
  );
endmodule

// File: tb/tb_cfg_aspect_ram.sv
module tb_cfg_aspect_ram;
  logic        rstN = 1'b0;
  logic [1:0]  shape = 2'b00;
  logic        asyncRd = 1'b0;
  logic        wrClk = 1'b0;
  logic        wrEn = 1'b0;
  logic [8:0]  wrAddr = '0;
  logic [17:0] wrData = '0;
  logic        rdClk = 1'b0;
  logic        rdEn = 1'b0;
  logic [8:0]  rdAddr = '0;
  logic [17:0] rdData;

  int checks = 0;
  int fails = 0;
  logic [17:0] refMem [0:511];

  cfg_aspect_ram dut (.*);

  always #10 wrClk = ~wrClk;   // 50 MHz write clock
  always #7  rdClk = ~rdClk;   // unrelated read clock

  function automatic int widthOf(input logic [1:0] s); return 18 >> s; endfunction
  function automatic int depthOf(input logic [1:0] s); return 64 << s; endfunction
  function automatic logic [17:0] dataMask(input logic [1:0] s);
    return 18'((1 << widthOf(s)) - 1);
  endfunction
  function automatic logic [17:0] expectAt(input logic [1:0] s, input logic [8:0] a);
    return refMem[int'(a) % depthOf(s)] & dataMask(s);
  endfunction

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [8:0] a, input logic [17:0] d, input logic en);
    @(negedge wrClk);
    wrAddr = a; wrData = d; wrEn = en;
    @(negedge wrClk);
    wrEn = 1'b0;
    if (en) refMem[int'(a) % depthOf(shape)] = d & dataMask(shape);
  endtask

  task automatic syncRead(input logic [8:0] a, input string req);
    @(negedge rdClk);
    rdAddr = a; rdEn = 1'b1;
    @(negedge rdClk);
    rdEn = 1'b0;
    chk(req, rdData, expectAt(shape, a));
  endtask

  task automatic asyncRead(input logic [8:0] a, input string req);
    rdAddr = a;
    #1;
    chk(req, rdData, expectAt(shape, a));
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [17:0] held;
    logic [8:0]  a;
    void'($urandom(32'd1234));
    repeat (3) @(negedge rdClk);
    chk("R9 reset clears read register", rdData, 18'h0);
    rstN = 1'b1;
    repeat (2) @(negedge rdClk);
    chk("R9 register zero after release", rdData, 18'h0);

    for (int s = 0; s < 4; s++) begin
      shape = 2'(s); asyncRd = 1'b0;
      for (int i = 0; i < 512; i++) refMem[i] = '0;
      // fill every word, random junk in high address bits
      for (int i = 0; i < depthOf(shape); i++)
        doWrite(9'(i + depthOf(shape) * ($urandom % 8)), 18'($urandom), 1'b1);
      for (int i = 0; i < depthOf(shape); i++)
        syncRead(9'(i), "R1 R10 R5 fill readback clocked");

      // R2 aliasing on high address bits
      a = 9'($urandom % depthOf(shape));
      doWrite(a | 9'(depthOf(shape) % 512), 18'h2AAAA, 1'b1);
      syncRead(a, "R2 high address bits ignored");
      // R3 high data bits not stored
      doWrite(a, 18'h3FFFF, 1'b1);
      syncRead(a, "R3 unused data bits read zero");
      // R4 write with enable low ignored
      doWrite(a, 18'h15555, 1'b0);
      syncRead(a, "R4 write without enable ignored");
      // R8 write then clocked read of same address
      doWrite(a, 18'($urandom), 1'b1);
      syncRead(a, "R8 write then clocked read");
      // R6 hold with enable low
      held = rdData;
      @(negedge rdClk);
      rdAddr = a ^ 9'h1;
      repeat (4) @(negedge rdClk);
      chk("R6 output held with enable low", rdData, held);

      // combinational read
      asyncRd = 1'b1;
      for (int i = 0; i < depthOf(shape); i++)
        asyncRead(9'(i + depthOf(shape) * ($urandom % 8)), "R7 R10 combinational readback");
      a = 9'($urandom);
      rdAddr = a;
      @(negedge wrClk);
      wrAddr = a; wrData = 18'($urandom); wrEn = 1'b1;
      @(negedge wrClk);
      wrEn = 1'b0;
      refMem[int'(a) % depthOf(shape)] = wrData & dataMask(shape);
      chk("R7 combinational read sees fresh write", rdData, expectAt(shape, a));
      for (int n = 0; n < 100; n++) begin
        if ($urandom % 2) doWrite(9'($urandom), 18'($urandom), 1'($urandom % 4 != 0));
        else asyncRead(9'($urandom), "R7 R2 R3 random combinational");
      end

      // random mix with clocked reads
      asyncRd = 1'b0;
      for (int n = 0; n < 100; n++) begin
        if ($urandom % 2) doWrite(9'($urandom), 18'($urandom), 1'($urandom % 4 != 0));
        else syncRead(9'($urandom), "R5 R2 R4 random clocked");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule